// File: doc/BRIEF.md
# Re-centering transmit elastic buffer

This block sits in a 155.52 Mb/s transmit path between a bit clock recovered from incoming NRZ data and a local reference clock. Both clocks run at the same nominal rate but wander slowly against each other. Serial data is written one bit per recovered-clock cycle into a small circular store. It is read out one bit per reference-clock cycle, so the read pointer trails the write pointer by about half the store. A bounded amount of phase wander then passes without any bit being lost or repeated.

The read side watches the distance between the two pointers, using a Gray-coded copy of the write pointer that crosses into the reference domain through a flop synchronizer. When the distance collapses to zero or grows to the top of the store, a sticky error flag rises. A re-center puts the pointers back about half the store apart, holds the output at 0 while the gap refills, and clears the flag. A re-center is started in three ways: by a rising edge on a command input, by the transmit loss-of-lock indication going low, and once after reset. When the source is not locked to the reference, a bypass input routes the incoming bit straight to the output.

Top module: `tx_elastic_buf`

## Requirements
- R1: With bypass low and phase wander of up to ±4 bit periods between the clocks, tx_bit reproduces the written bit stream in order with no bit lost or repeated, and ferr stays 0.
- R2: A 0-to-1 edge on recenter_req, sampled on rclk, re-centers the buffer. The synchronized write-to-read distance becomes DEPTH/2 − SYNC_STAGES (up to two more with wander), tx_bit is 0 for the next DEPTH/2 rclk cycles, and the written stream then resumes in order.
- R3: ferr goes to 1 when the synchronized write-to-read distance reaches 0 (underflow) or DEPTH − GUARD (overflow), whether the write clock runs persistently slow or fast.
- R4: Once set, ferr stays 1 until a re-center; a manual re-center clears it to 0.
- R5: A 1-to-0 transition of txlol, after SYNC_STAGES rclk synchronizer flops, triggers one re-center, which clears ferr; in-order data then resumes.
- R6: A 0-to-1 transition of txlol has no effect: ferr keeps its value and the output stream continues without a break.
- R7: With bypass high, tx_bit equals w_bit combinationally, with no register in between.
- R8: During reset tx_bit and ferr are 0. After rrst_n is released, an automatic re-center runs, and tx_bit is 0 for the first DEPTH/2 rclk cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Recovered bit clock (write side) |
| wrst_n | input | 1 | Active-low asynchronous reset, write side |
| w_bit | input | 1 | Serial data bit, sampled on wclk |
| rclk | input | 1 | Reference bit clock (read side) |
| rrst_n | input | 1 | Active-low asynchronous reset, read side |
| recenter_req | input | 1 | Re-center command; its rising edge acts, rclk domain |
| txlol | input | 1 | Transmit loss-of-lock indication, asynchronous |
| bypass | input | 1 | 1: pass w_bit straight to tx_bit; 0: retime through the buffer |
| tx_bit | output | 1 | Serial data out |
| ferr | output | 1 | Sticky overflow/underflow flag, rclk domain |

## Verification
The checker watches the read side on every rclk cycle. It checks that the output is 0 whenever the refill counter is active. It checks that every re-center leaves the synchronized distance in its centred band, starts a refill and clears ferr. It checks that ferr cannot fall without a re-center, and that a distance at the empty or full limit raises ferr on the next cycle.

Only the bench scenarios can show the end-to-end properties. These are in-order delivery across real wander of the write clock period, that true overflow and underflow occur under sustained frequency offset, and that a rising txlol is ignored while a falling one re-centers. They also cover the behaviour just after reset and the combinational bypass path.

// File: rtl/eb_pkg.sv
package eb_pkg;

  // Binary to reflected Gray code.
  function automatic int unsigned eb_bin2gray(input int unsigned b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary by a prefix XOR.
  function automatic int unsigned eb_gray2bin(input int unsigned g);
    int unsigned b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  // Distance outside the safe band: empty, or too close to full.
  function automatic logic eb_sep_bad(input int unsigned sep,
                                      input int unsigned depth,
                                      input int unsigned guard);
    return (sep == 0) || (sep >= depth - guard);
  endfunction

endpackage

// File: rtl/eb_sync.sv
module eb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side
  import eb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   wclk,
  input  logic                   wrst_n,
  input  logic                   w_bit,
  output logic [DEPTH-1:0]       store,
  output logic [$clog2(DEPTH):0] wgray
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr;
  logic [PW-1:0] wptr_nxt;

  assign wptr_nxt = wptr + PW'(1);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      store <= '0;
      wptr  <= '0;
      wgray <= '0;
    end else begin
      store[wptr[AW-1:0]] <= w_bit;
      wptr  <= wptr_nxt;
      wgray <= PW'(eb_bin2gray(32'(wptr_nxt)));
    end
  end

endmodule

// File: rtl/eb_rd_side.sv
module eb_rd_side
  import eb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int GUARD       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   rclk,
  input  logic                   rrst_n,
  input  logic [DEPTH-1:0]       store,
  input  logic [$clog2(DEPTH):0] wgray_s,
  input  logic                   recenter_req,
  input  logic                   lol_s,
  output logic                   rd_bit,
  output logic                   ferr,
  output logic                   recenter,
  output logic                   holding,
  output logic [$clog2(DEPTH):0] sep
);

  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam int OFFS = HALF - SYNC_STAGES;
  localparam int HW   = $clog2(HALF + 1);

  logic [PW-1:0] rptr;
  logic [PW-1:0] wbin;
  logic [HW-1:0] hold_cnt;
  logic          req_q, lol_q, boot_q;
  logic          req_rise, lol_fall, err_evt;

  assign wbin     = PW'(eb_gray2bin(32'(wgray_s)));
  assign sep      = wbin - rptr;
  assign err_evt  = eb_sep_bad(32'(sep), DEPTH, GUARD);
  assign req_rise = recenter_req & ~req_q;
  assign lol_fall = lol_q & ~lol_s;
  assign recenter = boot_q | req_rise | lol_fall;
  assign holding  = (hold_cnt != '0);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr     <= '0;
      hold_cnt <= '0;
      ferr     <= 1'b0;
      rd_bit   <= 1'b0;
      req_q    <= 1'b0;
      lol_q    <= 1'b0;
      boot_q   <= 1'b1;
    end else begin
      req_q  <= recenter_req;
      lol_q  <= lol_s;
      boot_q <= 1'b0;
      if (recenter) begin
        rptr     <= wbin - PW'(OFFS);
        hold_cnt <= HW'(HALF);
        ferr     <= 1'b0;
        rd_bit   <= 1'b0;
      end else begin
        rptr <= rptr + PW'(1);
        ferr <= ferr | err_evt;
        if (holding) begin
          hold_cnt <= hold_cnt - HW'(1);
          rd_bit   <= 1'b0;
        end else begin
          rd_bit <= store[rptr[AW-1:0]];
        end
      end
    end
  end

endmodule

// File: rtl/tx_elastic_buf.sv
module tx_elastic_buf #(
  parameter int DEPTH       = 16,
  parameter int GUARD       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic wclk,
  input  logic wrst_n,
  input  logic w_bit,
  input  logic rclk,
  input  logic rrst_n,
  input  logic recenter_req,
  input  logic txlol,
  input  logic bypass,
  output logic tx_bit,
  output logic ferr
);

  localparam int PW = $clog2(DEPTH) + 1;

  logic [DEPTH-1:0] store;
  logic [PW-1:0]    wgray;
  logic [PW-1:0]    wgray_s;
  logic             lol_s;
  logic             rd_bit;
  logic             recenter;
  logic             holding;
  logic [PW-1:0]    sep;

  eb_wr_side #(.DEPTH(DEPTH)) u_wr (
    .wclk  (wclk),
    .wrst_n(wrst_n),
    .w_bit (w_bit),
    .store (store),
    .wgray (wgray)
  );

  eb_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk  (rclk),
    .rst_n(rrst_n),
    .d    (wgray),
    .q    (wgray_s)
  );

  eb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lsync (
    .clk  (rclk),
    .rst_n(rrst_n),
    .d    (txlol),
    .q    (lol_s)
  );

  eb_rd_side #(.DEPTH(DEPTH), .GUARD(GUARD), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .rclk        (rclk),
    .rrst_n      (rrst_n),
    .store       (store),
    .wgray_s     (wgray_s),
    .recenter_req(recenter_req),
    .lol_s       (lol_s),
    .rd_bit      (rd_bit),
    .ferr        (ferr),
    .recenter    (recenter),
    .holding     (holding),
    .sep         (sep)
  );

  assign tx_bit = bypass ? w_bit : rd_bit;

endmodule

// File: rtl/tx_elastic_buf_chk.sv
module tx_elastic_buf_chk #(
  parameter int DEPTH       = 16,
  parameter int GUARD       = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                   rclk,
  input logic                   rrst_n,
  input logic                   bypass,
  input logic                   tx_bit,
  input logic                   ferr,
  input logic                   recenter,
  input logic                   holding,
  input logic [$clog2(DEPTH):0] sep
);

  localparam int PW   = $clog2(DEPTH) + 1;
  localparam int OFFS = DEPTH / 2 - SYNC_STAGES;

  // R2: while refilling, the retimed output is forced low
  p_hold_zero_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    (holding && !bypass) |-> (tx_bit == 1'b0));

  // R2: a re-center starts a refill
  p_hold_start_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    recenter |=> holding);

  // R2: a re-center puts the synchronized distance in its centred band
  p_center_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    recenter |=> ((sep >= PW'(OFFS)) && (sep <= PW'(OFFS + 2))));

  // R3: empty or near-full distance raises the flag next cycle
  p_err_set_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!recenter && ((sep == '0) || (sep >= PW'(DEPTH - GUARD)))) |=> ferr);

  // R4: the flag only falls through a re-center
  p_ferr_sticky_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ferr && !recenter) |=> ferr);

  // R5: every re-center clears the flag
  p_recenter_clears_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    recenter |=> !ferr);

endmodule

bind tx_elastic_buf tx_elastic_buf_chk #(
  .DEPTH(DEPTH), .GUARD(GUARD), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .rclk    (rclk),
  .rrst_n  (rrst_n),
  .bypass  (bypass),
  .tx_bit  (tx_bit),
  .ferr    (ferr),
  .recenter(recenter),
  .holding (holding),
  .sep     (sep)
);

// File: tb/tx_elastic_buf_test.sv
module tx_elastic_buf_test;

  localparam int CLK_PERIOD = 6430;
  localparam int DEPTH      = 16;
  localparam int HALF       = DEPTH / 2;
  localparam int WIN        = 32;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0;
  logic w_bit = 0, recenter_req = 0, txlol = 0, bypass = 0;
  logic tx_bit, ferr;

  int whalf = CLK_PERIOD / 2;
  int errs = 0, checks = 0;
  int mon_mode = 0;
  int mism = 0, compared = 0;
  int found;
  bit ok;
  logic [14:0] lfsr = 15'h0001;
  bit wq[$];
  bit rwin[$];

  tx_elastic_buf uut (
    .wclk(wclk), .wrst_n(wrst_n), .w_bit(w_bit),
    .rclk(rclk), .rrst_n(rrst_n),
    .recenter_req(recenter_req), .txlol(txlol), .bypass(bypass),
    .tx_bit(tx_bit), .ferr(ferr)
  );

  always #(CLK_PERIOD / 2) rclk = ~rclk;
  initial begin
    #1111;
    forever #(whalf) wclk = ~wclk;
  end

  // Driver: a new PRBS bit each write cycle, pushed as the expected item.
  always @(negedge wclk) begin
    if (wrst_n) begin
      lfsr  = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
      w_bit = lfsr[0];
      wq.push_back(lfsr[0]);
    end
  end

  // Monitor: 0 idle, 1 aligning on a window, 2 popping and comparing, 3 lost.
  always @(negedge rclk) begin
    case (mon_mode)
      0: while (wq.size() > 64) void'(wq.pop_front());
      1: begin
        while (wq.size() > 80) void'(wq.pop_front());
        rwin.push_back(tx_bit);
        if (rwin.size() == WIN) begin
          found = -1;
          for (int k = 0; k + WIN <= wq.size(); k++) begin
            ok = 1;
            for (int i = 0; i < WIN; i++) if (wq[k+i] != rwin[i]) ok = 0;
            if (ok && found < 0) found = k;
          end
          if (found >= 0) begin
            for (int i = 0; i < found + WIN; i++) void'(wq.pop_front());
            mon_mode = 2;
          end else begin
            mon_mode = 3;
          end
        end
      end
      2: begin
        if (wq.size() == 0) mism++;
        else if (wq.pop_front() != tx_bit) mism++;
        compared++;
      end
      default: ;
    endcase
  end

  task automatic check(input bit pass, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!pass) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic relock(input string req, input int n);
    mon_mode = 0;
    rwin.delete();
    wait_r(HALF + 6);
    mism = 0;
    compared = 0;
    mon_mode = 1;
    wait_r(n + WIN + 8);
    check(mon_mode == 2, req, "stream alignment state", mon_mode, 2);
    check(mism == 0 && compared >= n, req, "bits out of order", mism, 0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    int zeros;
    // R8: reset values and the refill after release
    wait_r(3);
    check(tx_bit == 1'b0, "R8", "tx_bit in reset", tx_bit, 0);
    check(ferr == 1'b0, "R8", "ferr in reset", ferr, 0);
    @(negedge rclk);
    wrst_n = 1;
    rrst_n = 1;
    zeros = 0;
    repeat (HALF) begin
      @(negedge rclk);
      if (tx_bit != 1'b0) zeros++;
    end
    check(zeros == 0, "R8", "nonzero bits during boot refill", zeros, 0);

    // R1: matched clocks, in-order stream
    relock("R1", 300);
    check(ferr == 1'b0, "R1", "ferr with matched clocks", ferr, 0);

    // R1: wander of about three bit periods each way, stream stays aligned
    mism = 0; compared = 0;
    whalf = CLK_PERIOD / 2 + 32;  wait_r(300);
    whalf = CLK_PERIOD / 2 - 32;  wait_r(600);
    whalf = CLK_PERIOD / 2 + 32;  wait_r(300);
    whalf = CLK_PERIOD / 2;       wait_r(100);
    check(mon_mode == 2 && mism == 0 && compared >= 1200, "R1",
          "bits out of order under wander", mism, 0);
    check(ferr == 1'b0, "R1", "ferr under bounded wander", ferr, 0);

    // R6: rising loss-of-lock while streaming does not disturb anything
    mism = 0; compared = 0;
    @(negedge rclk) txlol = 1;
    wait_r(100);
    check(mon_mode == 2 && mism == 0 && compared >= 100, "R6",
          "stream broken by txlol rise", mism, 0);
    // R5: falling loss-of-lock re-centers, refill then in-order data
    @(negedge rclk) txlol = 0;
    relock("R5", 200);

    // R2: manual re-center, DEPTH/2 zeros, then the stream resumes
    mon_mode = 0;
    @(negedge rclk) recenter_req = 1;
    @(negedge rclk) begin
      recenter_req = 0;
      zeros = (tx_bit != 1'b0) ? 1 : 0;
    end
    repeat (HALF - 1) begin
      @(negedge rclk);
      if (tx_bit != 1'b0) zeros++;
    end
    check(zeros == 0, "R2", "nonzero bits during refill", zeros, 0);
    relock("R2", 200);

    // R3: sustained fast writer overflows
    mon_mode = 0;
    whalf = CLK_PERIOD / 2 - 32;
    wait_r(1500);
    check(ferr == 1'b1, "R3", "ferr after overflow", ferr, 1);
    // R4: sticky after the offset is removed
    whalf = CLK_PERIOD / 2;
    wait_r(100);
    check(ferr == 1'b1, "R4", "ferr held without re-center", ferr, 1);
    // R6: rising loss-of-lock does not clear the flag
    @(negedge rclk) txlol = 1;
    wait_r(30);
    check(ferr == 1'b1, "R6", "ferr after txlol rise", ferr, 1);
    // R5: falling loss-of-lock clears it
    @(negedge rclk) txlol = 0;
    wait_r(6);
    check(ferr == 1'b0, "R5", "ferr after txlol fall", ferr, 0);
    relock("R5", 150);

    // R3: sustained slow writer underflows
    mon_mode = 0;
    whalf = CLK_PERIOD / 2 + 32;
    wait_r(1500);
    check(ferr == 1'b1, "R3", "ferr after underflow", ferr, 1);
    whalf = CLK_PERIOD / 2;
    wait_r(50);
    // R4: manual re-center clears the flag
    @(negedge rclk) recenter_req = 1;
    @(negedge rclk) recenter_req = 0;
    wait_r(2);
    check(ferr == 1'b0, "R4", "ferr after manual re-center", ferr, 0);
    relock("R2", 150);

    // R7: bypass follows the input between write edges
    mon_mode = 0;
    @(negedge rclk) bypass = 1;
    zeros = 0;
    repeat (24) begin
      @(negedge wclk);
      #1500;
      if (tx_bit != w_bit) zeros++;
    end
    check(zeros == 0, "R7", "bypass samples differing from w_bit", zeros, 0);
    @(negedge rclk) bypass = 0;

    finish_run();
  end

endmodule